// File: doc/BRIEF.md
# Lattice Coset Parity Constraint Generator

This block sits beside the child-selection stage of a real-valued, depth-first tree search. It limits the search to the points of one coset of the eight-dimensional Gosset lattice. That lattice is the set of integer vectors whose bitwise parities form a word of the (8,4,4) extended Hamming code. For the tree level being visited, the block reports one of two outcomes. The level may be unconstrained, so any point of the PAM alphabet may be chosen. Otherwise the level is restricted to one parity class of PAM indices, and the block gives the parity bit that class needs.

The search starts at dimension 7 and works down to dimension 0. The block takes three things: the step count, the parity bits of the indices already chosen, and a 4-bit coset selector. The selector picks one of the 16 cosets of the Hamming code, so one block serves every branch-metric decoder in a bank.

The block also helps the enumerator. It raises a flag that tells the zigzag to step by two on constrained levels. It tests whether a rounded candidate index has the right parity. It moves a candidate with the wrong parity to the nearest legal neighbour. All outputs are combinational, so they fit in the same cycle as the child selection.

Top module: `lattice_coset_gen`

## Requirements
- R1: For steps 0 to 3, which visit dimensions 7, 6, 5 and 4, lvl_free_o is 1, skip2_o is 0 and cand_ok_o is 1, and near_idx_o equals cand_idx_o's input cand_idx_i.
- R2: Step k visits dimension 7-k. For k from 4 to 7, lvl_free_o is 0. req_par_o is then the XOR of coset_sel_i[7-k] with the chosen parities (chosen_par_i bit n belongs to dimension n) taken from this set: dims {4,5,6} for dimension 0, {4,5,7} for dimension 1, {4,6,7} for dimension 2, {5,6,7} for dimension 3.
- R3: skip2_o is 1 exactly on steps 4 to 7 and 0 elsewhere.
- R4: The parity of a PAM index is its bit 0. cand_ok_o is 1 when the level is free or when cand_idx_i[0] equals req_par_o, and 0 otherwise.
- R5: When cand_ok_o is 0 and round_up_i is 1, near_idx_o is cand_idx_i+1, or cand_idx_i-1 if cand_idx_i is the top index. When round_up_i is 0, near_idx_o is cand_idx_i-1, or 1 if cand_idx_i is 0.
- R6: Bits of chosen_par_i for the dimension being visited and for all dimensions below it have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| step_i | input | 3 | Number of levels already decided; visited dimension is 7-step_i |
| chosen_par_i | input | 8 | Parity (index bit 0) of the value chosen per dimension |
| coset_sel_i | input | 4 | Coset selector, XORed into the parity of dimensions 0..3 |
| cand_idx_i | input | PAM_IW | Rounded candidate PAM index for this level |
| round_up_i | input | 1 | Preferred direction for moving an illegal candidate |
| lvl_free_o | output | 1 | Level accepts any PAM index |
| req_par_o | output | 1 | Required index parity on a constrained level |
| skip2_o | output | 1 | Enumerator must step by two indices |
| cand_ok_o | output | 1 | Candidate index satisfies the constraint |
| near_idx_o | output | PAM_IW | Candidate, or its nearest legal neighbour |

## Verification
The assertions assume that every input is a known value whenever they evaluate, and they skip evaluation while any input is unknown. They also assume that cand_idx_i stays within the alphabet, which holds for any value of its width. The stimulus drives every step, every coset selector, every candidate index and both rounding directions, and it combines these with several random parity vectors. It then re-randomises only the bits of dimensions not yet decided and checks that the outputs do not move.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
   localparam int NDIM   = 8;
   localparam int NINFO  = 4;
   localparam int STEP_W = $clog2(NDIM);

   typedef enum logic [1:0] {
      CLS_FREE = 2'b00,
      CLS_EVEN = 2'b10,
      CLS_ODD  = 2'b11
   } par_cls_e;

   // information dimensions feeding the check of parity dimension j
   function automatic logic [NDIM-1:0] check_mask(input int j);
      case (j)
         0:       check_mask = 8'b0111_0000;
         1:       check_mask = 8'b1011_0000;
         2:       check_mask = 8'b1101_0000;
         default: check_mask = 8'b1110_0000;
      endcase
   endfunction
endpackage

// File: rtl/lcg_parity_bank.sv
module lcg_parity_bank
   import lcg_pkg::*;
(
   input  logic [NDIM-1:0]  chosen_i,
   input  logic [NINFO-1:0] sel_i,
   output logic [NINFO-1:0] req_o
);
   for (genvar j = 0; j < NINFO; j++) begin : g_chk
      localparam logic [NDIM-1:0] MASK = check_mask(j);
      assign req_o[j] = ^(chosen_i & MASK) ^ sel_i[j];
   end
endmodule

// File: rtl/lcg_level_sel.sv
module lcg_level_sel
   import lcg_pkg::*;
(
   input  logic [STEP_W-1:0] step_i,
   input  logic [NINFO-1:0]  req_i,
   output par_cls_e          cls_o
);
   localparam int PW = $clog2(NINFO);
   logic [STEP_W-1:0] dim;
   logic [PW-1:0]     pidx;

   always_comb begin
      dim  = STEP_W'(NDIM - 1) - step_i;
      pidx = dim[PW-1:0];
      if (step_i < STEP_W'(NDIM - NINFO))
         cls_o = CLS_FREE;
      else if (req_i[pidx])
         cls_o = CLS_ODD;
      else
         cls_o = CLS_EVEN;
   end
endmodule

// File: rtl/lcg_nearest.sv
module lcg_nearest
   import lcg_pkg::*;
#(
   parameter int IW = 2
) (
   input  par_cls_e       cls_i,
   input  logic [IW-1:0]  cand_i,
   input  logic           up_i,
   output logic           ok_o,
   output logic [IW-1:0]  near_o
);
   localparam logic [IW-1:0] TOP = {IW{1'b1}};
   localparam logic [IW-1:0] ONE = IW'(1);

   always_comb begin
      ok_o = (cls_i == CLS_FREE) || (cand_i[0] == cls_i[0]);
      if (ok_o)
         near_o = cand_i;
      else if (up_i)
         near_o = (cand_i == TOP) ? cand_i - ONE : cand_i + ONE;
      else
         near_o = (cand_i == '0) ? ONE : cand_i - ONE;
   end

   always_comb begin
      if (!$isunknown({cls_i, cand_i, up_i}) && !ok_o) begin
         assert_near_adjacent_R5: assert ((near_o == cand_i + ONE) || (near_o == cand_i - ONE))
            else $error("R5: moved index not adjacent");
      end
   end
endmodule

// File: rtl/lattice_coset_gen.sv
module lattice_coset_gen
   import lcg_pkg::*;
#(
   parameter int PAM_IW = 2
) (
   input  logic [2:0]        step_i,
   input  logic [7:0]        chosen_par_i,
   input  logic [3:0]        coset_sel_i,
   input  logic [PAM_IW-1:0] cand_idx_i,
   input  logic              round_up_i,
   output logic              lvl_free_o,
   output logic              req_par_o,
   output logic              skip2_o,
   output logic              cand_ok_o,
   output logic [PAM_IW-1:0] near_idx_o
);
   if (PAM_IW < 1 || PAM_IW > 6) begin : g_bad_iw
      $error("PAM_IW must be in 1..6");
   end
   if (STEP_W != 3 || NDIM != 8 || NINFO != 4) begin : g_bad_dim
      $error("package dimensions do not match the port widths");
   end

   logic [NINFO-1:0] req_vec;
   par_cls_e         cls;

   lcg_parity_bank u_bank (
      .chosen_i (chosen_par_i),
      .sel_i    (coset_sel_i),
      .req_o    (req_vec)
   );

   lcg_level_sel u_lvl (
      .step_i (step_i),
      .req_i  (req_vec),
      .cls_o  (cls)
   );

   lcg_nearest #(.IW(PAM_IW)) u_near (
      .cls_i  (cls),
      .cand_i (cand_idx_i),
      .up_i   (round_up_i),
      .ok_o   (cand_ok_o),
      .near_o (near_idx_o)
   );

   assign lvl_free_o = (cls == CLS_FREE);
   assign req_par_o  = cls[0];
   assign skip2_o    = cls[1];

   always_comb begin
      if (!$isunknown({step_i, chosen_par_i, coset_sel_i, cand_idx_i, round_up_i})) begin
         if (step_i < 3'd4) begin
            assert_first_free_R1: assert (lvl_free_o && cand_ok_o && near_idx_o == cand_idx_i)
               else $error("R1: upper level constrained");
         end
         if (skip2_o) begin
            assert_skip_levels_R3: assert (!lvl_free_o && step_i >= 3'd4)
               else $error("R3: skip on free level");
         end
         if (!lvl_free_o) begin
            assert_near_parity_R5: assert (near_idx_o[0] == req_par_o)
               else $error("R5: nearest index has wrong parity");
         end
         if (cand_ok_o) begin
            assert_ok_passthru_R4: assert (near_idx_o == cand_idx_i)
               else $error("R4: legal candidate was moved");
         end
      end
   end
endmodule

// File: tb/lattice_coset_gen_tb_top.sv
module lattice_coset_gen_tb_top;
   localparam int IW  = 2;
   localparam int TOP = (1 << IW) - 1;

   logic          clk = 1'b0;
   logic [2:0]    step;
   logic [7:0]    chosen;
   logic [3:0]    sel;
   logic [IW-1:0] cand;
   logic          up;
   logic          free_o, req_o, skip_o, ok_o;
   logic [IW-1:0] near_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lattice_coset_gen #(.PAM_IW(IW)) dut_i (
      .step_i(step), .chosen_par_i(chosen), .coset_sel_i(sel),
      .cand_idx_i(cand), .round_up_i(up),
      .lvl_free_o(free_o), .req_par_o(req_o), .skip2_o(skip_o),
      .cand_ok_o(ok_o), .near_idx_o(near_o)
   );

   function automatic int ref_req(int st, logic [7:0] c, logic [3:0] s);
      int d = 7 - st;
      case (d)
         0: return c[4] ^ c[5] ^ c[6] ^ s[0];
         1: return c[4] ^ c[5] ^ c[7] ^ s[1];
         2: return c[4] ^ c[6] ^ c[7] ^ s[2];
         default: return c[5] ^ c[6] ^ c[7] ^ s[3];
      endcase
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d (step=%0d sel=%0d chosen=%b cand=%0d up=%0b)",
                  tag, act, exp, step, sel, chosen, cand, up);
      end
   endtask

   task automatic drive(int st, logic [7:0] c, int s, int ca, int u);
      @(posedge clk);
      step = 3'(st); chosen = c; sel = 4'(s); cand = IW'(ca); up = 1'(u);
      @(negedge clk);
   endtask

   task automatic compare_all();
      int st = int'(step);
      int ca = int'(cand);
      bit fr = (st < 4);
      int rq = fr ? 0 : ref_req(st, chosen, sel);
      bit ok = fr || ((ca & 1) == rq);
      int nr;
      if (ok) nr = ca;
      else if (up) nr = (ca == TOP) ? ca - 1 : ca + 1;
      else nr = (ca == 0) ? 1 : ca - 1;
      if (fr) begin
         chk("R1 free", int'(free_o), 1);
         chk("R1 ok", int'(ok_o), 1);
         chk("R1 near", int'(near_o), ca);
      end else begin
         chk("R2 free", int'(free_o), 0);
         chk("R2 req", int'(req_o), rq);
      end
      chk("R3 skip", int'(skip_o), fr ? 0 : 1);
      chk("R4 ok", int'(ok_o), int'(ok));
      chk("R5 near", int'(near_o), nr);
   endtask

   initial begin
      step = '0; chosen = '0; sel = '0; cand = '0; up = 1'b0;
      @(negedge clk);
      compare_all();
      for (int st = 0; st < 8; st++)
         for (int s = 0; s < 16; s++)
            for (int rep = 0; rep < 3; rep++) begin
               logic [7:0] c = (rep == 0) ? 8'h00 : (rep == 1) ? 8'hFF : 8'($urandom);
               for (int ca = 0; ca <= TOP; ca++)
                  for (int u = 0; u < 2; u++) begin
                     drive(st, c, s, ca, u);
                     compare_all();
                  end
            end
      // R6: undecided bits (visited dimension and below) must not matter
      for (int k = 0; k < 400; k++) begin
         int st = k % 8;
         logic [7:0] c = 8'($urandom);
         logic [7:0] umask = 8'((1 << (8 - st)) - 1);
         int s = int'($urandom % 16);
         int ca = int'($urandom % (TOP + 1));
         int u = int'($urandom % 2);
         logic [IW+3:0] first;
         drive(st, c, s, ca, u);
         first = {free_o, req_o, skip_o, ok_o, near_o};
         drive(st, c ^ (8'($urandom) & umask), s, ca, u);
         chk("R6 undecided bits", int'({free_o, req_o, skip_o, ok_o, near_o}), int'(first));
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule